// File: doc/BRIEF.md
# Quad DAC Double-Buffered Register Front End

This block is the digital register front end of a four-channel digital-to-analog converter. Each channel holds two registers in series. The first one is an input holding register, and it is written from a shared parallel data bus at a channel address. The second one is an output register, and it drives the converter code for that channel. Data reaches the outputs only through an update. The update copies every holding register into its output register in the same clock cycle.

The host drives active-low strobes, a 2-bit address and a data word. The block samples all of these through a synchroniser on its own system clock, and it acts on the sampled levels. A load happens while the chip select and the latch strobe are both low. An update happens while the chip select is low and every other strobe is high. Because of this, the order in which the host releases the latch strobe and the chip select decides the result. If the chip select rises first, the data stays preloaded. If the latch strobe rises first, the outputs take the new data. With these two orders the host can update one channel at a time, update all channels together, or preload channels for a later common update. An 8-bit mode word is written through the same data bus, under its own select strobe.

Top module: `quad_dac_frontend`

## Requirements
- R1: While `rst_n` is low, every holding register and every output code is mid-scale (only the MSB set, 12'h800 at the default width), and `mode_word` is 0. This takes effect at once, with no clock edge needed.
- R2: All pins pass through a two-stage synchroniser. A pin condition present at rising clock edge n is applied at edge n+2, using the address and data sampled at edge n. Nothing changes before that edge.
- R3: While `cs_n`=0, `ls_n`=0 and `ms_n`=1, the data word is written into the holding register of the channel given by `addr` (value k selects channel k). The outputs do not change.
- R4: During a load, every channel that is not addressed keeps its holding register.
- R5: While `cs_n`=0 and `ls_n`, `ms_n`, `tr_n`, `rd_n`, `rst_n` are all 1, every channel's output code takes that channel's holding value in the same cycle. `addr` and `data` are ignored.
- R6: An update leaves the holding registers unchanged. A repeated update therefore gives the same outputs.
- R7: A preload is a load ended by `cs_n` rising while `ls_n` is still low. It does not change any output code.
- R8: A load ended by `ls_n` rising while `cs_n` is still low puts the new word on that channel's output.
- R9: If several channels are loaded during one long `cs_n` low period, and `ls_n` then rises before `cs_n`, all of those outputs change in the same cycle.
- R10: If each channel gets its own `cs_n` assertion, and `ls_n` rises before `cs_n` each time, the outputs change one channel at a time, in the order the channels were written.
- R11: While `cs_n`=0, `ms_n`=0 and `ls_n`=1, `mode_word` takes `data[7:0]`. No holding register and no output changes.
- R12: While `cs_n` is low with `tr_n` or `rd_n` low and `ls_n` high, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every pin is sampled on its rising edge |
| cs_n | input | 1 | Chip select, active low |
| ls_n | input | 1 | Latch strobe for holding-register loads, active low |
| ms_n | input | 1 | Mode word select, active low |
| tr_n | input | 1 | Transfer control, active low; while low it blocks updates |
| rd_n | input | 1 | Readback control, active low; while low it blocks updates |
| rst_n | input | 1 | Register clear to mid-scale, active low; asserts asynchronously |
| addr | input | 2 | Channel address used for loads |
| data | input | 12 | Data word; the low 8 bits form the mode word |
| dac_code | output | 4x12 | Output codes, one packed 12-bit word per channel |
| mode_word | output | 8 | Stored mode select word |

## Verification
The hardest case to produce from the ports is telling a common update (R9) apart from a channel-by-channel update (R10). In both, the final output values are the same. Only the cycle in which each output changes differs. The bench therefore logs the cycle of every output change. It drives one long chip-select window with several loads and a final latch-strobe release. It then drives a descending sequence of single-channel windows. It compares the logged change cycles for equality in the first case and for strict order in the second. Preload windows, where the chip select rises while the latch strobe is still low, are placed between updates to show that the outputs hold.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef struct packed {
    logic cs_n;
    logic ls_n;
    logic ms_n;
    logic tr_n;
    logic rd_n;
    logic rst_n;
  } ctl_t;

  // Value the control synchroniser holds during reset: strobes idle, clear active
  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, ls_n: 1'b1, ms_n: 1'b1,
                                tr_n: 1'b1, rd_n: 1'b1, rst_n: 1'b0};

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_LOAD   = 2'd1,
    OP_UPDATE = 2'd2,
    OP_MODE   = 2'd3
  } op_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
(
  input  ctl_t ctl,
  output op_e  op,
  output logic clear
);
  always_comb begin
    op    = OP_IDLE;
    clear = !ctl.rst_n;
    if (ctl.rst_n && !ctl.cs_n) begin
      if (!ctl.ls_n && ctl.ms_n)
        op = OP_LOAD;
      else if (ctl.ls_n && !ctl.ms_n)
        op = OP_MODE;
      else if (ctl.ls_n && ctl.ms_n && ctl.tr_n && ctl.rd_n)
        op = OP_UPDATE;
    end
  end
endmodule

// File: rtl/qdac_ranks.sv
module qdac_ranks
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          arst_n,
  input  logic                          clear,
  input  op_e                           op,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             data,
  output logic [NUM_CH-1:0][DATA_W-1:0] first_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] second_o
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    assign hit = (op == OP_LOAD) && (addr == ADDR_W'(ch));

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     first_o[ch] <= MID;
      else if (clear)  first_o[ch] <= MID;
      else if (hit)    first_o[ch] <= data;
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                second_o[ch] <= MID;
      else if (clear)             second_o[ch] <= MID;
      else if (op == OP_UPDATE)   second_o[ch] <= first_o[ch];
    end
  end
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
  import qdac_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 12,
  parameter int MODE_W  = 8,
  parameter int SYNC_N  = 2,
  parameter int ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                          clk,
  input  logic                          cs_n,
  input  logic                          ls_n,
  input  logic                          ms_n,
  input  logic                          tr_n,
  input  logic                          rd_n,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             data,
  output logic [NUM_CH-1:0][DATA_W-1:0] dac_code,
  output logic [MODE_W-1:0]             mode_word
);
  localparam int CTL_W = $bits(ctl_t);
  localparam int BUS_W = ADDR_W + DATA_W;

  ctl_t                          ctl_raw, ctl_s;
  logic [ADDR_W-1:0]             addr_s;
  logic [DATA_W-1:0]             data_s;
  op_e                           op_w;
  logic                          clear_w;
  logic [NUM_CH-1:0][DATA_W-1:0] first_w;

  assign ctl_raw = '{cs_n: cs_n, ls_n: ls_n, ms_n: ms_n,
                     tr_n: tr_n, rd_n: rd_n, rst_n: rst_n};

  qdac_sync #(.W(CTL_W), .STAGES(SYNC_N), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .arst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  // Address and data follow the same depth so they stay aligned with the strobes
  qdac_sync #(.W(BUS_W), .STAGES(SYNC_N), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .arst_n(rst_n), .d({addr, data}), .q({addr_s, data_s})
  );

  qdac_decode u_dec (.ctl(ctl_s), .op(op_w), .clear(clear_w));

  qdac_ranks #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ranks (
    .clk(clk), .arst_n(rst_n), .clear(clear_w), .op(op_w),
    .addr(addr_s), .data(data_s), .first_o(first_w), .second_o(dac_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mode_word <= '0;
    else if (clear_w)        mode_word <= '0;
    else if (op_w == OP_MODE) mode_word <= data_s[MODE_W-1:0];
  end
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int MODE_W = 8,
  parameter int ADDR_W = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input op_e                           op,
  input logic [ADDR_W-1:0]             addr_s,
  input logic [DATA_W-1:0]             data_s,
  input logic [NUM_CH-1:0][DATA_W-1:0] first,
  input logic [NUM_CH-1:0][DATA_W-1:0] dac,
  input logic [MODE_W-1:0]             mode
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1
      reset_mid_chk: assert (first == {NUM_CH{MID}} && dac == {NUM_CH{MID}} && mode == '0);
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R3
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LOAD && addr_s == ADDR_W'(ch)) |=> first[ch] == $past(data_s));
    // R4
    load_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LOAD && addr_s != ADDR_W'(ch)) |=> $stable(first[ch]));
  end

  // R5
  update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_UPDATE) |=> dac == $past(first));
  // R6
  update_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_UPDATE) |=> $stable(first));
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_UPDATE) |=> $stable(dac));
  // R11
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MODE) |=> mode == $past(data_s[MODE_W-1:0]));
endmodule

bind quad_dac_frontend qdac_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .MODE_W(MODE_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .op(op_w), .addr_s(addr_s), .data_s(data_s),
  .first(first_w), .dac(dac_code), .mode(mode_word)
);

// File: tb/quad_dac_frontend_tb_top.sv
module quad_dac_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam int MID = 12'h800;

  logic clk = 1'b0;
  logic cs_n = 1'b1, ls_n = 1'b1, ms_n = 1'b1, tr_n = 1'b1, rd_n = 1'b1;
  logic rst_n = 1'b1;
  logic [1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [NCH-1:0][DW-1:0] dac_code;
  logic [7:0] mode_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_dac_frontend dut_i (
    .clk(clk), .cs_n(cs_n), .ls_n(ls_n), .ms_n(ms_n), .tr_n(tr_n),
    .rd_n(rd_n), .rst_n(rst_n), .addr(addr), .data(data),
    .dac_code(dac_code), .mode_word(mode_word)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  // Behavioural reference: pin history delayed by two sampling edges
  typedef struct { bit cs, ls, ms, tr, rd, rs; int a; int d; } pins_t;
  pins_t hist[2];
  int m_first[NCH];
  int m_out[NCH];
  int m_mode;
  int prev[NCH];
  int chg[NCH];

  function automatic pins_t idle_pins();
    pins_t p;
    p.cs = 1; p.ls = 1; p.ms = 1; p.tr = 1; p.rd = 1; p.rs = 0; p.a = 0; p.d = 0;
    return p;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NCH; i++) begin m_first[i] = MID; m_out[i] = MID; end
    m_mode = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
      hist[0] = idle_pins();
      hist[1] = idle_pins();
    end else begin
      pins_t e, now;
      e = hist[0];
      now.cs = cs_n; now.ls = ls_n; now.ms = ms_n; now.tr = tr_n;
      now.rd = rd_n; now.rs = rst_n; now.a = int'(addr); now.d = int'(data);
      hist[0] = hist[1];
      hist[1] = now;
      if (!e.rs) model_clear();
      else if (!e.cs) begin
        if (!e.ls && e.ms) m_first[e.a] = e.d;
        else if (e.ls && !e.ms) m_mode = e.d % 256;
        else if (e.ls && e.ms && e.tr && e.rd)
          for (int i = 0; i < NCH; i++) m_out[i] = m_first[i];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Compare against the model every cycle, and log output change cycles
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < NCH; i++) begin
      chk(int'(dac_code[i]) == m_out[i], {"R2/", cur_req}, int'(dac_code[i]), m_out[i]);
      if (int'(dac_code[i]) != prev[i]) chg[i] = cyc;
      prev[i] = int'(dac_code[i]);
    end
    chk(int'(mode_word) == m_mode, {"R2/", cur_req}, int'(mode_word), m_mode);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit c, input bit l, input bit m, input bit t,
                       input bit r, input int a, input int d);
    cs_n = c; ls_n = l; ms_n = m; tr_n = t; rd_n = r;
    addr = 2'(a); data = DW'(d);
  endtask

  task automatic all_mid(input string req);
    for (int i = 0; i < NCH; i++) chk(dac_code[i] == MID, req, int'(dac_code[i]), MID);
    chk(mode_word == 0, req, int'(mode_word), 0);
  endtask

  initial begin
    int s;
    for (int i = 0; i < NCH; i++) begin prev[i] = MID; chg[i] = 0; end
    #1 rst_n = 1'b0;
    tick(3);
    all_mid("R1");
    rst_n = 1'b1;
    tick(4);

    // Preload channel 1 only: CS rises while LS is still low
    cur_req = "R3";
    drive(0, 0, 1, 1, 1, 1, 'h123); tick(2);
    drive(1, 0, 1, 1, 1, 1, 'h123); tick(2);
    drive(1, 1, 1, 1, 1, 0, 0);     tick(4);
    chk(dac_code[1] == MID, "R7", int'(dac_code[1]), MID);
    chk(dac_code[0] == MID, "R4", int'(dac_code[0]), MID);

    // Plain update with a stray address; latency check
    cur_req = "R5";
    drive(0, 1, 1, 1, 1, 3, 'hFFF); tick(2);
    chk(dac_code[1] == MID, "R2", int'(dac_code[1]), MID);
    tick(1);
    chk(dac_code[1] == 'h123, "R5", int'(dac_code[1]), 'h123);
    chk(dac_code[3] == MID, "R5", int'(dac_code[3]), MID);
    drive(1, 1, 1, 1, 1, 0, 0); tick(4);
    drive(0, 1, 1, 1, 1, 2, 'h0AB); tick(2);
    drive(1, 1, 1, 1, 1, 0, 0); tick(4);
    chk(dac_code[1] == 'h123, "R6", int'(dac_code[1]), 'h123);

    // One long CS window, three loads, LS rises first
    cur_req = "R9";
    drive(0, 0, 1, 1, 1, 0, 'hAAA); tick(2);
    drive(0, 0, 1, 1, 1, 2, 'h555); tick(2);
    drive(0, 0, 1, 1, 1, 3, 'h0F0); tick(2);
    drive(0, 1, 1, 1, 1, 3, 'h0F0); tick(2);
    drive(1, 1, 1, 1, 1, 0, 0);     tick(4);
    chk(chg[0] == chg[2], "R9", chg[0], chg[2]);
    chk(chg[2] == chg[3], "R9", chg[2], chg[3]);
    chk(dac_code[2] == 'h555, "R9", int'(dac_code[2]), 'h555);

    // Separate CS window per channel, written 3,2,1,0
    cur_req = "R10";
    for (int i = 3; i >= 0; i--) begin
      drive(0, 0, 1, 1, 1, i, 'h100 + i*17); tick(2);
      drive(0, 1, 1, 1, 1, i, 'h100 + i*17); tick(2);
      drive(1, 1, 1, 1, 1, 0, 0);            tick(3);
      chk(int'(dac_code[i]) == 'h100 + i*17, "R8", int'(dac_code[i]), 'h100 + i*17);
    end
    chk(chg[3] < chg[2], "R10", chg[3], chg[2]);
    chk(chg[2] < chg[1], "R10", chg[2], chg[1]);
    chk(chg[1] < chg[0], "R10", chg[1], chg[0]);

    // Mode word write
    cur_req = "R11";
    drive(0, 1, 0, 1, 1, 1, 'h35A); tick(2);
    drive(1, 1, 1, 1, 1, 0, 0);     tick(4);
    chk(mode_word == 8'h5A, "R11", int'(mode_word), 'h5A);
    chk(dac_code[0] == 'h100, "R11", int'(dac_code[0]), 'h100);

    // Blocked updates while TR or RD is low
    cur_req = "R12";
    drive(0, 0, 1, 1, 1, 0, 'h777); tick(2);
    drive(1, 0, 1, 1, 1, 0, 'h777); tick(2);
    drive(1, 1, 1, 1, 1, 0, 0);     tick(2);
    drive(0, 1, 1, 0, 1, 0, 0);     tick(3);
    drive(1, 1, 1, 1, 1, 0, 0);     tick(3);
    chk(dac_code[0] == 'h100, "R12", int'(dac_code[0]), 'h100);
    drive(0, 1, 1, 1, 0, 0, 0);     tick(3);
    drive(1, 1, 1, 1, 1, 0, 0);     tick(3);
    chk(dac_code[0] == 'h100, "R12", int'(dac_code[0]), 'h100);
    drive(0, 1, 1, 1, 1, 0, 0);     tick(2);
    drive(1, 1, 1, 1, 1, 0, 0);     tick(4);
    chk(dac_code[0] == 'h777, "R6", int'(dac_code[0]), 'h777);

    // Reset during operation acts at once
    cur_req = "R1";
    #1 rst_n = 1'b0;
    #1 all_mid("R1");
    tick(2);
    rst_n = 1'b1;
    tick(4);
    all_mid("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule